// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block is the receive half of a descriptor-driven DMA engine. Software builds a circular chain of 16-byte descriptors in host memory. Each descriptor holds four 32-bit words: the byte address of the next descriptor at offset 0, a status word at offset 4, a buffer byte address at offset 8, and a buffer length word at offset 12. Software then points the block at the first descriptor and pulses `start`.

For each descriptor, the engine first reads the status word. A descriptor is free while status bit 15 is clear. For a free descriptor the engine fetches the buffer address, the length and the next pointer. It then accepts one frame from a byte stream and packs the bytes into 32-bit words at the buffer. Last, it writes back a status word that carries bit 15 set, the stored length and error flags. It then moves on to the next descriptor.

If the descriptor is still held by the host, the engine stalls the stream. It reads that status word again after a programmable poll interval. The host hands a descriptor back by writing its status to zero.

Top module: `rx_ring_writer`

## Requirements
- R1: After `start`, the engine reads the descriptor at `list_base` in this order: status (word +1), buffer address (word +2), length (word +3), next pointer (word +0). All addresses on `mem_addr` are word addresses, equal to the byte address shifted right by 2.
- R2: Frame byte k goes to word `buffer/4 + k/4`, in byte lane `k%4` (little-endian). Only the lanes that hold frame bytes are enabled on `mem_be`, so memory bytes past the frame end are left unchanged.
- R3: After the last data word, the engine writes the status word. Bit 15 is 1, bits 12..0 hold the stored byte count, and all other bits are 0 when the frame is clean.
- R4: A frame whose `rx_err` is high on any accepted byte is still stored and completed. Its status has bit 16 set, and the engine then proceeds to the next descriptor.
- R5: When a frame is longer than the buffer size (length word bits 12..0), bytes beyond the size are accepted but not written. The status length equals the size, and bit 17 is set.
- R6: A descriptor whose status bit 15 is set is unavailable. `rx_ready` stays low and no write is issued. The status word is read again exactly `poll_period*UNIT_CYCLES + 3` cycles after the previous read completed, measured when each access is acknowledged once per two cycles.
- R7: The engine follows each descriptor's next pointer, so a ring whose last pointer leads back to the first descriptor wraps around.
- R8: A memory request stays asserted, with stable address, direction and write data, until `mem_ack`. `rx_ready` is never high while a request is pending.
- R9: After reset and before `start`, `mem_req` and `rx_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse: load the list pointer and begin walking the ring |
| list_base | input | 32 | Byte address of the first descriptor |
| poll_period | input | POLL_W | Re-fetch interval for a busy descriptor, in units of UNIT_CYCLES |
| rx_valid | input | 1 | Frame byte valid |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | Byte is the last byte of the frame |
| rx_err | input | 1 | Frame is bad (sampled with each byte) |
| rx_ready | output | 1 | Byte accepted on this edge if `rx_valid` is high |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | 30 | Word address |
| mem_be | output | 4 | Byte enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access completes on this edge |

## Verification
Two functions can meet in the same cycle. The first is the truncation cut-off: the byte that fills the buffer forces a word write. The second is the frame end, which forces the status write. The bench provokes both by feeding frames that end exactly on, and past, the buffer size. It judges the result by the memory lanes left untouched and by the length and overflow bits in the status. Polling and stream back-pressure also collide. A frame is offered while the next descriptor is still owned by the host. The bench then checks three things: the stream stays stalled, the re-read spacing is exact, and the frame lands intact once the host frees the descriptor.

// File: rtl/rx_ring_writer.sv
module rx_ring_writer #(
  parameter int UNIT_CYCLES = 1,
  parameter int POLL_W      = 8,
  parameter int LEN_W       = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       list_base,
  input  logic [POLL_W-1:0] poll_period,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_last,
  input  logic              rx_err,
  output logic              rx_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [29:0]       mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ack
);
  localparam int CW = POLL_W + $clog2(UNIT_CYCLES + 1) + 1;

  typedef enum logic [3:0] {
    S_IDLE, S_STAT, S_BUF, S_SIZE, S_NEXT, S_WAIT, S_RECV, S_DATA, S_DONE
  } st_t;

  st_t              state;
  logic [29:0]      cur, nxt, wptr;
  logic [LEN_W-1:0] size, cnt;
  logic [31:0]      wbuf;
  logic [3:0]       be;
  logic             f_err, f_trunc, f_last;
  logic [CW-1:0]    poll_cnt;
  logic [CW-1:0]    poll_lim;
  logic             room, flush;

  assign poll_lim = CW'(poll_period) * CW'(UNIT_CYCLES);
  assign room     = cnt < size;
  assign flush    = (cnt[1:0] == 2'd3) || rx_last || ((cnt + LEN_W'(1)) == size);

  assign rx_ready = (state == S_RECV);
  assign mem_req  = (state == S_STAT) || (state == S_BUF) || (state == S_SIZE) ||
                    (state == S_NEXT) || (state == S_DATA) || (state == S_DONE);
  assign mem_we   = (state == S_DATA) || (state == S_DONE);
  assign mem_be   = (state == S_DATA) ? be : 4'hF;
  assign mem_wdata = (state == S_DATA) ? wbuf :
                     {14'b0, f_trunc, f_err, 1'b1, {(15-LEN_W){1'b0}}, cnt};

  always_comb begin
    case (state)
      S_STAT, S_DONE: mem_addr = cur + 30'd1;
      S_BUF:          mem_addr = cur + 30'd2;
      S_SIZE:         mem_addr = cur + 30'd3;
      S_DATA:         mem_addr = wptr;
      default:        mem_addr = cur;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cur      <= '0;
      nxt      <= '0;
      wptr     <= '0;
      size     <= '0;
      cnt      <= '0;
      wbuf     <= '0;
      be       <= '0;
      f_err    <= 1'b0;
      f_trunc  <= 1'b0;
      f_last   <= 1'b0;
      poll_cnt <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          cur   <= list_base[31:2];
          state <= S_STAT;
        end
        S_STAT: if (mem_ack) begin
          if (mem_rdata[15]) begin
            poll_cnt <= '0;
            state    <= S_WAIT;
          end else begin
            state <= S_BUF;
          end
        end
        S_WAIT: begin
          if (poll_cnt >= poll_lim) state <= S_STAT;
          else poll_cnt <= poll_cnt + CW'(1);
        end
        S_BUF: if (mem_ack) begin
          wptr  <= mem_rdata[31:2];
          state <= S_SIZE;
        end
        S_SIZE: if (mem_ack) begin
          size  <= mem_rdata[LEN_W-1:0];
          state <= S_NEXT;
        end
        S_NEXT: if (mem_ack) begin
          nxt     <= mem_rdata[31:2];
          cnt     <= '0;
          wbuf    <= '0;
          be      <= '0;
          f_err   <= 1'b0;
          f_trunc <= 1'b0;
          f_last  <= 1'b0;
          state   <= S_RECV;
        end
        S_RECV: if (rx_valid) begin
          f_err  <= f_err | rx_err;
          f_last <= rx_last;
          if (room) begin
            wbuf[{cnt[1:0], 3'b000} +: 8] <= rx_data;
            be[cnt[1:0]] <= 1'b1;
            cnt <= cnt + LEN_W'(1);
            if (flush) state <= S_DATA;
          end else begin
            f_trunc <= 1'b1;
            if (rx_last) state <= (be != 4'b0) ? S_DATA : S_DONE;
          end
        end
        S_DATA: if (mem_ack) begin
          be    <= '0;
          wbuf  <= '0;
          wptr  <= wptr + 30'd1;
          state <= f_last ? S_DONE : S_RECV;
        end
        S_DONE: if (mem_ack) begin
          cur   <= nxt;
          state <= S_STAT;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rx_ring_writer_chk.sv
module rx_ring_writer_chk #(
  parameter int POLL_W = 8,
  parameter int LEN_W  = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              mem_ack,
  input logic              mem_we,
  input logic [29:0]       mem_addr,
  input logic [3:0]        mem_be,
  input logic [31:0]       mem_wdata,
  input logic [31:0]       mem_rdata,
  input logic              rx_ready,
  input logic [POLL_W-1:0] poll_period,
  input logic [29:0]       cur_w,
  input logic [LEN_W-1:0]  size_q
);
  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R8
  no_rx_during_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !rx_ready);

  // R3
  done_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && mem_addr == cur_w + 30'd1 |-> mem_wdata[15]);

  // R5
  len_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && mem_addr == cur_w + 30'd1 |-> mem_wdata[LEN_W-1:0] <= size_q);

  // R6
  owned_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && !mem_we && mem_addr == cur_w + 30'd1 && mem_rdata[15] && poll_period != '0
    |=> !mem_req);

  // R2
  lane_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_be != 4'b0);
endmodule

bind rx_ring_writer rx_ring_writer_chk #(.POLL_W(POLL_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_ack(mem_ack), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
  .rx_ready(rx_ready), .poll_period(poll_period), .cur_w(cur), .size_q(size)
);

// File: tb/rx_ring_writer_bench.sv
module rx_ring_writer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int POLL = 20;

  logic        clk = 0, rst_n = 0, start = 0;
  logic [31:0] list_base = 32'h100;
  logic [7:0]  poll_period = 8'(POLL);
  logic        rx_valid = 0, rx_last = 0, rx_err = 0;
  logic [7:0]  rx_data = 0;
  logic        rx_ready, mem_req, mem_we, mem_ack;
  logic [29:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata, mem_rdata;

  logic [31:0] mem [0:1023];
  logic [29:0] rd_log [0:63];
  int          rd_n = 0, wr_n = 0, cyc = 0;
  int          st_t [0:63];
  int          st_n = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_ring_writer u_rx_ring_writer (
    .clk(clk), .rst_n(rst_n), .start(start), .list_base(list_base),
    .poll_period(poll_period), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_last(rx_last), .rx_err(rx_err), .rx_ready(rx_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  assign mem_rdata = mem[mem_addr[9:0]];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) mem_ack <= 1'b0;
    else mem_ack <= mem_req && !mem_ack;
    if (mem_req && mem_ack) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[9:0]][8*b +: 8] <= mem_wdata[8*b +: 8];
        wr_n <= wr_n + 1;
      end else begin
        if (rd_n < 64) rd_log[rd_n] <= mem_addr;
        rd_n <= rd_n + 1;
        if (mem_addr == 30'h41 && st_n < 64) begin
          st_t[st_n] <= cyc;
          st_n <= st_n + 1;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_at(input int wbase, input int j);
    return mem[wbase + j/4][8*(j%4) +: 8];
  endfunction

  task automatic send_frame(input int n, input logic [7:0] seed, input bit err);
    for (int i = 0; i < n; i++) begin
      rx_valid = 1; rx_data = seed + 8'(i); rx_last = (i == n-1); rx_err = err && (i == n-1);
      while (!rx_ready) @(negedge clk);
      @(negedge clk);
    end
    rx_valid = 0; rx_last = 0; rx_err = 0;
  endtask

  task automatic wait_done(input int sw, input string req);
    int t = 0;
    while (!mem[sw][15] && t < 2000) begin @(negedge clk); t++; end
    check(mem[sw][15], req, mem[sw], 32'h8000);
  endtask

  task automatic check_bytes(input int wb, input int n, input logic [7:0] seed, input int pad, input string req);
    bit ok = 1;
    for (int j = 0; j < n; j++) if (byte_at(wb, j) != seed + 8'(j)) ok = 0;
    check(ok, req, byte_at(wb, 0), seed);
    if (pad > 0) begin
      ok = 1;
      for (int j = n; j < n + pad; j++) if (byte_at(wb, j) != 8'hEE) ok = 0;
      check(ok, req, byte_at(wb, n), 8'hEE);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    // R9
    check(!mem_req, "R9", mem_req, 0);
    check(!rx_ready, "R9", rx_ready, 0);
  endtask

  task automatic t_fetch;
    start = 1; @(negedge clk); start = 0;
    repeat (12) @(negedge clk);
    // R1
    check(rd_n >= 4 && rd_log[0] == 30'h41 && rd_log[1] == 30'h42 && rd_log[2] == 30'h43 &&
          rd_log[3] == 30'h40, "R1", {rd_log[0][7:0], rd_log[1][7:0], rd_log[2][7:0], rd_log[3][7:0]},
          32'h41424340);
  endtask

  task automatic t_plain;
    send_frame(10, 8'h10, 0);
    wait_done(32'h41, "R3");
    check(mem[32'h41] == 32'h0000800A, "R3", mem[32'h41], 32'h0000800A);
    check_bytes(32'h100, 10, 8'h10, 2, "R2");
  endtask

  task automatic t_error;
    send_frame(5, 8'h30, 1);
    wait_done(32'h45, "R4");
    check(mem[32'h45] == 32'h00018005, "R4", mem[32'h45], 32'h00018005);
    check_bytes(32'h140, 5, 8'h30, 3, "R4");
  endtask

  task automatic t_trunc;
    send_frame(9, 8'h60, 0);
    wait_done(32'h49, "R5");
    check(mem[32'h49] == 32'h00028006, "R5", mem[32'h49], 32'h00028006);
    check_bytes(32'h180, 6, 8'h60, 2, "R5");
  endtask

  task automatic t_owned_then_wrap;
    bit stalled = 1;
    int w0, s0;
    repeat (4) @(negedge clk);
    w0 = wr_n; s0 = st_n;
    rx_valid = 1; rx_data = 8'h50; rx_last = 0;
    for (int i = 0; i < 120; i++) begin
      if (rx_ready) stalled = 0;
      @(negedge clk);
    end
    // R6
    check(stalled, "R6", !stalled, 0);
    check(wr_n == w0, "R6", wr_n - w0, 0);
    check(st_n - s0 >= 3 && st_t[st_n-1] - st_t[st_n-2] == POLL + 3, "R6",
          st_t[st_n-1] - st_t[st_n-2], POLL + 3);
    mem[32'h41] = 32'h0;
    send_frame(4, 8'h50, 0);
    wait_done(32'h41, "R7");
    // R7
    check(mem[32'h41] == 32'h00008004, "R7", mem[32'h41], 32'h00008004);
    check_bytes(32'h100, 4, 8'h50, 0, "R7");
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'hEEEEEEEE;
    for (int k = 0; k < 3; k++) begin
      mem[32'h40 + 4*k]     = 32'h100 + 32'(16 * ((k + 1) % 3));
      mem[32'h40 + 4*k + 1] = 32'h0;
      mem[32'h40 + 4*k + 2] = 32'h400 + 32'(32'h100 * k);
      mem[32'h40 + 4*k + 3] = 32'h80000000 | ((k == 2) ? 32'd6 : 32'd64);
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_fetch();
    t_plain();
    t_error();
    t_trunc();
    t_owned_then_wrap();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule